// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gathers execution statistics for a processor cluster. It holds one free-running clock-cycle counter and four event counters. Each event counter counts one-cycle pulses on its own event input. Software reaches all state through a simple synchronous write port and a combinational read port. Through these ports it can start and stop counting, zero the counters in two groups, preload any counter, inspect overflow status and choose which overflows raise the interrupt line.

When a counter passes its all-ones value it wraps to zero and leaves a sticky overflow mark. Software removes a mark by writing a one to it. One registered interrupt request goes high while any marked overflow also has its enable bit set. The unit does not choose where its events come from, and it does not decode any system bus.

Top module: `perfmon_unit`

## Requirements
- R1: The word address map is: 0 control, 1 cycle counter, 2 to 5 event counters 0 to 3, 6 overflow flags, 7 interrupt enables. Reads are combinational on `addr`. After reset every register reads zero and `irq_o` is low.
- R2: Control bit 0 is the run enable and reads back as written. Control bits 1 and 2 are strobes that always read zero. A control write takes effect at the clock edge where it is presented.
- R3: While the run enable is set, the cycle counter rises by one at every clock edge. While the run enable is clear, it holds its value.
- R4: While the run enable is set, event counter k rises by one at every edge where `evt_i[k]` is high. While the run enable is clear, events are ignored.
- R5: A cycle counter at 0xFFFFFFFF that counts becomes 0 and sets flag bit 0.
- R6: An event counter k at 0xFFFFFFFF that counts an event becomes 0 and sets flag bit k+1.
- R7: A control write with bit 2 set zeroes the cycle counter at that edge. No increment and no overflow happen in that cycle.
- R8: A control write with bit 1 set zeroes all four event counters at that edge. Events in that cycle are dropped.
- R9: Writing a counter's address loads the written value. The load takes priority over an increment in the same cycle, so no increment is applied.
- R10: Flag bits are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An overflow in the same cycle as a clear of that bit leaves the bit set.
- R11: `irq_o` is a register output. It is high exactly when some flag bit and its matching enable bit are both set, and it changes at the same edge as those registers.
- R12: Writes to addresses 8 to 15 change nothing, and reads from them return zero. Flag and enable bits above bit 4 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| evt_i | input | 4 | One-cycle event pulses, one per event counter |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The risky overlaps are a software action and a hardware update landing in the same cycle. Four such collisions are provoked on purpose: a counter load while its increment or event is active, a group reset strobe while events pulse, and a write-one-to-clear of a flag bit at the very edge where that counter wraps. A behavioural reference model steps once per clock and is compared with the read port and the interrupt line every cycle. Directed reads then confirm the winning side of each collision: the loaded value, zero after a reset strobe, and a flag that stays set.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    // Word addresses whose order the read decode relies on
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_CYC      = 1;
    localparam int ADDR_EVT_BASE = 2;

    // Control register bit positions
    localparam int CTRL_RUN     = 0;
    localparam int CTRL_EVT_RST = 1;
    localparam int CTRL_CYC_RST = 2;

    typedef struct packed {
        logic run;
    } ctrl_t;

endpackage

// File: rtl/perfmon_ctr.sv
module perfmon_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (clear) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = (cnt_q == {W{1'b1}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/perfmon_irq.sv
module perfmon_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic         ien_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] ien_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] ien;
        logic         irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [N-1:0] clr_mask;
        clr_mask    = clr_we ? wdata : '0;
        st_d        = st_q;
        st_d.flag   = (st_q.flag & ~clr_mask) | set_i;
        if (ien_we) st_d.ien = wdata;
        st_d.irq    = |(st_d.flag & st_d.ien);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign ien_o  = st_q.ien;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 4,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic [CNT_W-1:0]   rdata,
    output logic               irq_o
);

    localparam int NUM_CTR   = NUM_EVT + 1;
    localparam int ADDR_FLAG = ADDR_EVT_BASE + NUM_EVT;
    localparam int ADDR_IEN  = ADDR_FLAG + 1;

    ctrl_t ctrl_d, ctrl_q;
    logic  run_en;
    logic  wr_ctrl;

    logic [CNT_W-1:0]   cnt  [NUM_CTR];
    logic [NUM_CTR-1:0] wrap;
    logic [NUM_CTR-1:0] flag_q, ien_q;

    assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    assign run_en  = ctrl_q.run;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) ctrl_d.run = wdata[CTRL_RUN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Counter 0 counts clock cycles, counters 1..NUM_EVT count events
    generate
        for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
            logic inc_k, clr_k;
            if (k == 0) begin : g_cyc
                assign inc_k = run_en;
                assign clr_k = wr_ctrl && wdata[CTRL_CYC_RST];
            end else begin : g_evt
                assign inc_k = run_en && evt_i[k-1];
                assign clr_k = wr_ctrl && wdata[CTRL_EVT_RST];
            end
            perfmon_ctr #(.W(CNT_W)) u_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (wr_en && (addr == ADDR_W'(ADDR_CYC + k))),
                .load_val (wdata),
                .clear    (clr_k),
                .inc      (inc_k),
                .cnt_o    (cnt[k]),
                .wrap_o   (wrap[k])
            );
        end
    endgenerate

    perfmon_irq #(.N(NUM_CTR)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wrap),
        .clr_we (wr_en && (addr == ADDR_W'(ADDR_FLAG))),
        .ien_we (wr_en && (addr == ADDR_W'(ADDR_IEN))),
        .wdata  (wdata[NUM_CTR-1:0]),
        .flag_o (flag_q),
        .ien_o  (ien_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) rdata[CTRL_RUN] = ctrl_q.run;
        if (addr == ADDR_W'(ADDR_FLAG)) rdata[NUM_CTR-1:0] = flag_q;
        if (addr == ADDR_W'(ADDR_IEN))  rdata[NUM_CTR-1:0] = ien_q;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (addr == ADDR_W'(ADDR_CYC + k)) rdata = cnt[k];
        end
    end

endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk
    import perfmon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 4,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [CNT_W-1:0]   wdata,
    input logic [CNT_W-1:0]   rdata,
    input logic               irq_o,
    input logic               run_en,
    input logic [CNT_W-1:0]   cyc,
    input logic [NUM_EVT:0]   flag,
    input logic [NUM_EVT:0]   ien
);

    localparam int ADDR_FLAG = ADDR_EVT_BASE + NUM_EVT;

    logic [NUM_EVT:0] clr_mask;
    assign clr_mask = (wr_en && addr == ADDR_W'(ADDR_FLAG)) ? wdata[NUM_EVT:0] : '0;

    // R3
    cyc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !wr_en) |=> (cyc == $past(cyc) + 1'b1));

    // R3
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> $stable(cyc));

    // R5
    cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !wr_en && cyc == {CNT_W{1'b1}}) |=> (cyc == '0 && flag[0]));

    // R9
    cyc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADDR_CYC)) |=> (cyc == $past(wdata)));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flag & $past(flag & ~clr_mask)) == $past(flag & ~clr_mask)));

    // R11
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(flag & ien));

    // R2
    strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(ADDR_CTRL)) |-> (rdata[CTRL_CYC_RST:CTRL_EVT_RST] == 2'b00));

endmodule

bind perfmon_unit perfmon_unit_chk #(
    .CNT_W   (CNT_W),
    .NUM_EVT (NUM_EVT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .irq_o  (irq_o),
    .run_en (run_en),
    .cyc    (cnt[0]),
    .flag   (flag_q),
    .ien    (ien_q)
);

// File: tb/perfmon_unit_test.sv
`timescale 1ns/1ps
module perfmon_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  evt_i = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    perfmon_unit uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .evt_i (evt_i),
        .rdata (rdata),
        .irq_o (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_cyc;
    logic [31:0] m_ev [4];
    logic [4:0]  m_flg, m_ien;
    logic        m_en;

    always @(posedge clk) begin : model
        logic [4:0] hit;
        logic [4:0] clr;
        if (!rst_n) begin
            m_cyc = 0; m_flg = 0; m_ien = 0; m_en = 0;
            for (int i = 0; i < 4; i++) m_ev[i] = 0;
        end else begin
            hit = 0;
            clr = (wr_en && addr == 6) ? wdata[4:0] : 5'b0;
            if (wr_en && addr == 1) m_cyc = wdata;
            else if (wr_en && addr == 0 && wdata[2]) m_cyc = 0;
            else if (m_en) begin
                if (m_cyc == 32'hFFFF_FFFF) hit[0] = 1'b1;
                m_cyc = m_cyc + 1;
            end
            for (int i = 0; i < 4; i++) begin
                if (wr_en && addr == 4'(i + 2)) m_ev[i] = wdata;
                else if (wr_en && addr == 0 && wdata[1]) m_ev[i] = 0;
                else if (m_en && evt_i[i]) begin
                    if (m_ev[i] == 32'hFFFF_FFFF) hit[i+1] = 1'b1;
                    m_ev[i] = m_ev[i] + 1;
                end
            end
            m_flg = (m_flg & ~clr) | hit;
            if (wr_en && addr == 7) m_ien = wdata[4:0];
            if (wr_en && addr == 0) m_en = wdata[0];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0: return {31'b0, m_en};
            4'd1: return m_cyc;
            4'd2, 4'd3, 4'd4, 4'd5: return m_ev[a - 2];
            4'd6: return {27'b0, m_flg};
            4'd7: return {27'b0, m_ien};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        case (a)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3, 4'd4, 4'd5: return "R4";
            4'd6: return "R10";
            4'd7: return "R11";
            default: return "R12";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag_for(addr), rdata, exp_rd(addr));
            check("R11", {31'b0, irq_o}, {31'b0, |(m_flg & m_ien)});
        end
    end

    // Drivers run at posedge + 1 ns
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        @(negedge clk);
        check(tag, rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 10; a++) rd(4'(a), 32'h0, "R1");
        check("R1", {31'b0, irq_o}, 32'h0);

        // R9 load while stopped, R3 hold
        wr(1, 32'h100);
        rd(1, 32'h100, "R9");
        rd(1, 32'h100, "R3");

        // R7 and R8 strobes with run enable, then R3 counting
        wr(0, 32'h7);
        rd(1, 32'h0, "R7");
        rd(1, 32'h1, "R3");
        rd(1, 32'h2, "R3");
        rd(0, 32'h1, "R2");

        // R4 events
        evt_i = 4'b0101;
        idle(3);
        evt_i = 4'b0000;
        rd(2, 32'd3, "R4");
        rd(3, 32'd0, "R4");
        rd(4, 32'd3, "R4");

        // R4 events ignored while stopped
        wr(0, 32'h0);
        evt_i = 4'b1111;
        idle(2);
        evt_i = 4'b0000;
        rd(2, 32'd3, "R4");

        // R5 cycle wrap
        wr(1, 32'hFFFF_FFFE);
        wr(7, 32'h1);
        wr(0, 32'h1);
        idle(2);
        rd(6, 32'h1, "R5");
        check("R11", {31'b0, irq_o}, 32'h1);

        // R6 event wrap
        wr(5, 32'hFFFF_FFFF);
        evt_i = 4'b1000;
        idle(1);
        evt_i = 4'b0000;
        rd(6, 32'h11, "R6");
        rd(5, 32'h0, "R6");

        // R10 write-one-to-clear, zeros ignored
        wr(6, 32'h1);
        rd(6, 32'h10, "R10");
        check("R11", {31'b0, irq_o}, 32'h0);
        wr(6, 32'h0);
        rd(6, 32'h10, "R10");

        // R10 hardware set beats clear in the same cycle
        wr(2, 32'hFFFF_FFFF);
        evt_i = 4'b0001;
        wr(6, 32'h2);
        evt_i = 4'b0000;
        rd(6, 32'h12, "R10");
        rd(2, 32'h0, "R6");

        // R9 load beats increment
        wr(1, 32'h50);
        rd(1, 32'h50, "R9");
        evt_i = 4'b0100;
        wr(4, 32'h7);
        evt_i = 4'b0000;
        rd(4, 32'h7, "R9");

        // R8 event reset beats events
        evt_i = 4'b1111;
        wr(0, 32'h3);
        evt_i = 4'b0000;
        rd(2, 32'h0, "R8");
        rd(5, 32'h0, "R8");
        rd(0, 32'h1, "R2");

        // R7 cycle reset while running
        wr(0, 32'h5);
        rd(1, 32'h0, "R7");

        // R12 unmapped address and upper bits
        wr(9, 32'hFFFF_FFFF);
        rd(9, 32'h0, "R12");
        wr(7, 32'hFFFF_FFFF);
        rd(7, 32'h1F, "R12");
        check("R11", {31'b0, irq_o}, 32'h1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule